// File: doc/BRIEF.md
# Banked Interrupt Controller with Next-Pending Scanner

This block gathers 96 level-sensitive peripheral request lines into three banks of 32 and drives one interrupt request towards the processor. Each bank has a raw status register that shows the request lines as they are. Each bank also has a mask of enabled lines, changed only through two write ports: one sets mask bits and one clears them. A software-visible control word is stored and read back, and it has no other effect. All of this sits behind a simple register bus. The bus is selected by `bus_sel`, and `bus_wr` marks a write. Reads are combinational from `bus_addr`.

A hardware scanner helps the service routine pick its next interrupt. The processor gives the last serviced global number and pulses `scan_start`. One cycle later the block reports the next enabled, pending interrupt number, taken in a fixed bank order. If none remains, it reports all ones.

The scanner is a two-state machine. `SCAN_IDLE` is the resting state. `SCAN_REPORT` holds the result for one cycle with `scan_done` high. The transition `IDLE->REPORT` is taken on `scan_start`. From `REPORT`, a new `scan_start` takes `REPORT->REPORT`, and otherwise `REPORT->IDLE` is taken.

Top module: `bank_intc`

## Requirements
- R1: After reset, all enable masks and the control word are zero, `irq_out` is low and `scan_done` is low.
- R2: Reads at byte offsets 0x00, 0x04 and 0x08 return the raw request lines of bank 0, 1 and 2, whatever the masks hold. Bank b is `irq_lines[32*b+31:32*b]`.
- R3: A write to the enable-set port sets the mask bits written as one and leaves the others unchanged. The set ports are 0x10 for bank 1, 0x14 for bank 2 and 0x18 for bank 0. A read of such a port returns that bank's mask.
- R4: A write to the enable-clear port clears the mask bits written as one. The clear ports are 0x1C for bank 1, 0x20 for bank 2 and 0x24 for bank 0. Writing all ones masks the whole bank. A read of such a port returns that bank's mask.
- R5: The control word at 0x0C reads back the last value written and changes neither `irq_out` nor the masks.
- R6: `irq_out` is high in the same cycle exactly when some line is both requesting and enabled.
- R7: Global numbering maps bank 1 to 0..31, bank 2 to 32..63 and bank 0 to 64..95. The scanner searches in ascending global order, so bank 1 comes first, then bank 2, then bank 0.
- R8: The scan begins at `scan_last`+1, with `scan_last` taken as 8-bit two's complement. A negative start is treated as 0.
- R9: The scanner considers only enabled, requesting lines. When none lies at or above the start point, `scan_found` is 0 and `scan_index` is 8'hFF.
- R10: `scan_done` is high in the cycle after each `scan_start` and low otherwise. The result reflects the lines and masks at the strobe edge.
- R11: Writes to pending offsets or unmapped offsets change nothing, and reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 96 | Level request lines, bank b in bits 32b+31..32b |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write when selected |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_out | output | 1 | Interrupt request to the processor |
| scan_start | input | 1 | Scanner start strobe |
| scan_last | input | 8 | Last serviced global number, signed |
| scan_done | output | 1 | Scanner result valid |
| scan_found | output | 1 | An interrupt was found |
| scan_index | output | 8 | Found global number, or 8'hFF |

## Verification
The bench checks each cross-wired set and clear port separately. A decoder that assumed numeric bank order would change the wrong mask, and the read-back would show it. Scans begin in the middle of a bank, exactly at a found index, at negative values and past the top. A wrong resume offset would return the same interrupt again. Mishandled sign would start at 96 or above. A numeric bank order would report 64 before 32. Lines that request while disabled are placed ahead of enabled ones, so a scanner that uses raw status would report them.

// File: rtl/intc_pkg.sv
package intc_pkg;
    typedef enum logic [0:0] {
        SCAN_IDLE   = 1'b0,
        SCAN_REPORT = 1'b1
    } scan_state_t;
endpackage

// File: rtl/intc_bank.sv
module intc_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] lines,
    output logic [W-1:0] en,
    output logic [W-1:0] active
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            en <= '0;
        else if (set_we)
            en <= en | wdata;
        else if (clr_we)
            en <= en & ~wdata;
    end

    assign active = lines & en;

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((en & $past(wdata)) == $past(wdata)));          // R3
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((en & $past(wdata)) == '0));                    // R4
endmodule

// File: rtl/intc_scanner.sv
module intc_scanner
    import intc_pkg::*;
#(
    parameter int W     = 32,
    parameter int NB    = 3,
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  last,
    input  logic [NB*W-1:0]   active_ord,
    output logic              done,
    output logic              found,
    output logic [IDX_W-1:0]  index
);
    localparam int TOTAL = NB * W;

    scan_state_t state_q, state_d;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    int               first;

    always_comb begin
        first = int'($signed(last)) + 1;
        if (first < 0)
            first = 0;
        hit     = 1'b0;
        hit_idx = '1;
        for (int i = TOTAL - 1; i >= 0; i--) begin
            if (active_ord[i] && (i >= first)) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCAN_IDLE:   state_d = start ? SCAN_REPORT : SCAN_IDLE;
            SCAN_REPORT: state_d = start ? SCAN_REPORT : SCAN_IDLE;
            default:     state_d = SCAN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SCAN_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            found <= 1'b0;
            index <= '1;
        end else if (start) begin
            found <= hit;
            index <= hit_idx;
        end
    end

    always_comb begin
        unique case (state_q)
            SCAN_IDLE:   done = 1'b0;
            SCAN_REPORT: done = 1'b1;
            default:     done = 1'b0;
        endcase
    end

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);                                            // R10
    AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);                                          // R10
    AST_NONE_ALLONES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> (index == '1));                        // R9
endmodule

// File: rtl/bank_intc.sv
module bank_intc #(
    parameter int  BANK_W    = 32,
    parameter int  NUM_BANKS = 3,
    parameter int  ADDR_W    = 8,
    localparam int TOTAL     = BANK_W * NUM_BANKS,
    localparam int IDX_W     = $clog2(TOTAL) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TOTAL-1:0]  irq_lines,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BANK_W-1:0] bus_wdata,
    output logic [BANK_W-1:0] bus_rdata,
    output logic              irq_out,
    input  logic              scan_start,
    input  logic [IDX_W-1:0]  scan_last,
    output logic              scan_done,
    output logic              scan_found,
    output logic [IDX_W-1:0]  scan_index
);
    localparam int CTRL_OFF = 4 * NUM_BANKS;
    localparam int SET_BASE = 4 * (NUM_BANKS + 1);
    localparam int CLR_BASE = 4 * (2 * NUM_BANKS + 1);

    logic                 wr_q;
    logic [BANK_W-1:0]    ctrl_q;
    logic [BANK_W-1:0]    en_w     [NUM_BANKS];
    logic [BANK_W-1:0]    act_w    [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_any;
    logic [TOTAL-1:0]     active_ord;
    logic [TOTAL-1:0]     en_all;

    assign wr_q = bus_sel && bus_wr;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int POS     = (b + NUM_BANKS - 1) % NUM_BANKS;
        localparam int SET_OFF = SET_BASE + 4 * POS;
        localparam int CLR_OFF = CLR_BASE + 4 * POS;
        logic set_we, clr_we;

        assign set_we = wr_q && (bus_addr == ADDR_W'(SET_OFF));
        assign clr_we = wr_q && (bus_addr == ADDR_W'(CLR_OFF));

        intc_bank #(.W(BANK_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (set_we),
            .clr_we (clr_we),
            .wdata  (bus_wdata),
            .lines  (irq_lines[b*BANK_W +: BANK_W]),
            .en     (en_w[b]),
            .active (act_w[b])
        );

        assign bank_any[b]                   = |act_w[b];
        assign en_all[b*BANK_W +: BANK_W]     = en_w[b];
        assign active_ord[POS*BANK_W +: BANK_W] = act_w[b];
    end

    assign irq_out = |bank_any;

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_q && (bus_addr == ADDR_W'(CTRL_OFF)))
            ctrl_q <= bus_wdata;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CTRL_OFF))
            bus_rdata = ctrl_q;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr == ADDR_W'(4 * b))
                bus_rdata = irq_lines[b*BANK_W +: BANK_W];
            if (bus_addr == ADDR_W'(SET_BASE + 4 * ((b + NUM_BANKS - 1) % NUM_BANKS)) ||
                bus_addr == ADDR_W'(CLR_BASE + 4 * ((b + NUM_BANKS - 1) % NUM_BANKS)))
                bus_rdata = en_w[b];
        end
    end

    intc_scanner #(.W(BANK_W), .NB(NUM_BANKS), .IDX_W(IDX_W)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (scan_start),
        .last       (scan_last),
        .active_ord (active_ord),
        .done       (scan_done),
        .found      (scan_found),
        .index      (scan_index)
    );

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_q && bus_addr == ADDR_W'(CTRL_OFF)) |=> $stable(ctrl_q)); // R5
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_all == '0) |-> !irq_out);                                // R6
    AST_IRQ_NOLINES: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lines == '0) |-> !irq_out);                             // R6
endmodule

// File: tb/bank_intc_test.sv
`timescale 1ns/1ps
module bank_intc_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [95:0] irq_lines;
    logic        bus_sel, bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        irq_out;
    logic        scan_start;
    logic [7:0]  scan_last;
    logic        scan_done, scan_found;
    logic [7:0]  scan_index;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_en [3];

    always #2 clk = ~clk;

    bank_intc uut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out),
        .scan_start(scan_start), .scan_last(scan_last),
        .scan_done(scan_done), .scan_found(scan_found), .scan_index(scan_index)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic int set_port(int b);
        return 8'h10 + 4 * ((b + 2) % 3);
    endfunction
    function automatic int clr_port(int b);
        return 8'h1C + 4 * ((b + 2) % 3);
    endfunction

    task automatic en_set(int b, logic [31:0] d);
        bus_write(8'(set_port(b)), d);
        m_en[b] = m_en[b] | d;
    endtask
    task automatic en_clr(int b, logic [31:0] d);
        bus_write(8'(clr_port(b)), d);
        m_en[b] = m_en[b] & ~d;
    endtask

    task automatic do_scan(string req, int last);
        logic ef;
        logic [7:0] ei;
        int s;
        ef = 1'b0; ei = 8'hFF;
        s = last + 1;
        if (s < 0) s = 0;
        for (int g = 95; g >= s; g--) begin
            int pb;
            pb = (g / 32 + 1) % 3;
            if (irq_lines[pb*32 + g%32] && m_en[pb][g%32]) begin
                ef = 1'b1; ei = 8'(g);
            end
        end
        @(negedge clk);
        scan_start = 1'b1; scan_last = 8'(last);
        @(negedge clk);
        scan_start = 1'b0;
        check({req, " done"}, 32'(scan_done), 32'd1);
        check({req, " found"}, 32'(scan_found), 32'(ef));
        check({req, " index"}, 32'(scan_index), 32'(ei));
        @(negedge clk);
        check("R10 done drops", 32'(scan_done), 32'd0);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        bus_read(8'h10, d); check("R1 enable bank1", d, 0);
        bus_read(8'h18, d); check("R1 enable bank0", d, 0);
        bus_read(8'h0C, d); check("R1 ctrl", d, 0);
        check("R1 irq_out", 32'(irq_out), 0);
        check("R1 scan_done", 32'(scan_done), 0);
    endtask

    task automatic t_pending;
        logic [31:0] d;
        irq_lines = {32'hC000_0001, 32'h1234_5678, 32'h8765_4321};
        bus_read(8'h00, d); check("R2 pending bank0", d, 32'h8765_4321);
        bus_read(8'h04, d); check("R2 pending bank1", d, 32'h1234_5678);
        bus_read(8'h08, d); check("R2 pending bank2", d, 32'hC000_0001);
        check("R6 masked lines no irq", 32'(irq_out), 0);
    endtask

    task automatic t_masks;
        logic [31:0] d;
        en_set(1, 32'h0000_00F0);
        en_set(1, 32'h0000_0001);
        bus_read(8'h10, d); check("R3 set bank1 accumulates", d, m_en[1]);
        bus_read(8'h14, d); check("R3 bank2 untouched", d, 0);
        en_set(2, 32'hA000_0000);
        bus_read(8'h14, d); check("R3 set bank2", d, m_en[2]);
        en_set(0, 32'h0000_FFFF);
        bus_read(8'h18, d); check("R3 set bank0", d, m_en[0]);
        en_clr(1, 32'h0000_0030);
        bus_read(8'h1C, d); check("R4 clear bank1", d, m_en[1]);
        en_clr(0, 32'hFFFF_FFFF);
        bus_read(8'h24, d); check("R4 all ones masks bank0", d, 0);
        bus_read(8'h20, d); check("R4 read bank2 via clear port", d, m_en[2]);
    endtask

    task automatic t_irq;
        irq_lines = '0;
        en_set(2, 32'h0000_0100);
        @(negedge clk); check("R6 no lines", 32'(irq_out), 0);
        irq_lines[64+8] = 1'b1;
        #1 check("R6 enabled line", 32'(irq_out), 1);
        en_clr(2, 32'h0000_0100);
        @(negedge clk); check("R6 after clear", 32'(irq_out), 0);
    endtask

    task automatic t_ctrl;
        logic [31:0] d;
        irq_lines = '0;
        bus_write(8'h0C, 32'hDEAD_BEEF);
        bus_read(8'h0C, d); check("R5 ctrl readback", d, 32'hDEAD_BEEF);
        check("R5 ctrl no irq", 32'(irq_out), 0);
        bus_read(8'h10, d); check("R5 ctrl no mask change", d, m_en[1]);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        irq_lines = '0;
        bus_write(8'h28, 32'hFFFF_FFFF);
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_read(8'h28, d); check("R11 unmapped reads zero", d, 0);
        bus_read(8'h00, d); check("R11 pending not writable", d, 0);
        bus_read(8'h10, d); check("R11 bank1 mask kept", d, m_en[1]);
        bus_read(8'h14, d); check("R11 bank2 mask kept", d, m_en[2]);
        bus_read(8'h18, d); check("R11 bank0 mask kept", d, m_en[0]);
        bus_read(8'h0C, d); check("R11 ctrl kept", d, 32'hDEAD_BEEF);
    endtask

    task automatic t_scan;
        for (int b = 0; b < 3; b++) en_set(b, 32'hFFFF_FFFF);
        irq_lines = '0;
        irq_lines[32+5]  = 1'b1;
        irq_lines[64+0]  = 1'b1;
        irq_lines[0+31]  = 1'b1;
        do_scan("R8 from -1", -1);
        do_scan("R7 after 5 into bank2", 5);
        do_scan("R7 after 32 into bank0", 32);
        do_scan("R9 after 95 none", 95);
        do_scan("R8 negative start", -100);
        do_scan("R9 start past top", 127);
        irq_lines[32+5] = 1'b0;
        do_scan("R7 empty bank1 skipped", -1);
        en_clr(2, 32'h0000_0001);
        do_scan("R9 disabled line ignored", 5);
        irq_lines[32+2] = 1'b1;
        irq_lines[32+7] = 1'b1;
        do_scan("R8 resume mid bank", 2);
        do_scan("R8 start at bit", 1);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; irq_lines = '0;
        bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        scan_start = 0; scan_last = 0;
        for (int b = 0; b < 3; b++) m_en[b] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pending();
        t_masks();
        t_irq();
        t_ctrl();
        t_unmapped();
        t_scan();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule